// File: doc/BRIEF.md
# Solinas-Prime Field Multiplier (448-bit)

This block multiplies two elements of the prime field GF(p), p = 2^448 − 2^224 − 1, and returns the fully reduced product. It serves as the multiply and square engine of an elliptic-curve arithmetic unit. Both operands stream in side by side as fourteen 32-bit words. Internally the operands are treated as 28 limbs of 16 bits. For one limb of B per cycle, 28 parallel 16×16 products are formed. Any product whose weight lands at or above 2^448 is folded straight back into the low columns, using the congruence 2^448 ≡ 2^224 + 1 (mod p). No separate reduction pass is needed.

After 28 accumulation cycles, a four-stage pipeline takes over. It collapses the column sums into one integer, folds the overflow back in twice and makes a final conditional subtraction of p. The result is then streamed out as fourteen 32-bit words. The next operand load may overlap that output. The completed result stays in a register, so either operand of the next operation can be taken from it instead of from the external word inputs. This serves squaring chains and multiplication chains without a memory round trip.

Top module: `solinas_mul448`

## Requirements
- R1: After reset, and until the first accepted start, res_valid_o is 0.
- R2: A start is taken when start_i is 1 while the block is idle. In that cycle, word 0 (bits 31:0) of both operands is presented on op_a_i and op_b_i. Words 1 to 13 follow on the next 13 cycles, least significant word first.
- R3: For any operands A and B below 2^448, not only below p, the result equals A·B mod p and lies in [0, p). This includes the inputs 0, 1, p−1 and 2^448−1.
- R4: If start is taken in cycle s, res_valid_o is 1 in cycles s+46 to s+59 and in no others. The result appears on res_o in those cycles, least significant word first.
- R5: A new start may be taken in cycle s+46, the first output cycle of the previous operation. The previous output stream is not disturbed, and the new result appears 46 cycles after its own start.
- R6: fb_a_i and fb_b_i are sampled with an accepted start. Each one, when set, makes its operand the most recent completed result for the whole load. The external words on that operand are then ignored.
- R7: start_i, fb_a_i, fb_b_i and the operand words have no effect from cycle s+1 to cycle s+45 of an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load; word 0 is presented in the same cycle |
| fb_a_i | input | 1 | Take operand A from the last result |
| fb_b_i | input | 1 | Take operand B from the last result |
| op_a_i | input | 32 | Operand A word, least significant word first |
| op_b_i | input | 32 | Operand B word, least significant word first |
| res_o | output | 32 | Result word |
| res_valid_o | output | 1 | Marks each valid result word |

## Verification
The hardest case to reach is a start arriving in the exact cycle that the previous result begins to leave the block. A back-to-back chain must also take its operands from the feedback path while the output stream still reads from the same result register. The stimulus reaches this by counting cycles from each accepted start. It issues the next start in cycle s+46, sometimes with both feedback selects set and garbage on the word inputs. Spurious starts are placed on the busy-window edges s+14, s+44 and s+45, and the stimulus confirms that no extra output stream appears.

// File: rtl/solinas_mul_pkg.sv
package solinas_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_MUL,
    ST_RED
  } mul_state_e;
endpackage

// File: rtl/sm_operand_load.sv
module sm_operand_load #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned N_WORD = 14,
  localparam int unsigned FIELD_W = WORD_W * N_WORD,
  localparam int unsigned IDX_W = $clog2(N_WORD)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               start_i,
  input  logic               fb_a_i,
  input  logic               fb_b_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [WORD_W-1:0]  ext_a_i,
  input  logic [WORD_W-1:0]  ext_b_i,
  input  logic [FIELD_W-1:0] fb_res_i,
  output logic [FIELD_W-1:0] a_o,
  output logic [FIELD_W-1:0] b_o
);
  logic fb_a_q, fb_b_q, sel_a, sel_b;
  logic [WORD_W-1:0] fb_word, word_a, word_b;
  logic [FIELD_W-1:0] a_q, b_q;

  // selects are live in the start cycle, latched for the remaining words
  assign sel_a   = start_i ? fb_a_i : fb_a_q;
  assign sel_b   = start_i ? fb_b_i : fb_b_q;
  assign fb_word = fb_res_i[idx_i*WORD_W +: WORD_W];
  assign word_a  = sel_a ? fb_word : ext_a_i;
  assign word_b  = sel_b ? fb_word : ext_b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_a_q <= 1'b0;
      fb_b_q <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
    end else begin
      if (start_i) begin
        fb_a_q <= fb_a_i;
        fb_b_q <= fb_b_i;
      end
      if (en_i) begin
        a_q <= {word_a, a_q[FIELD_W-1:WORD_W]};
        b_q <= {word_b, b_q[FIELD_W-1:WORD_W]};
      end
    end
  end

  assign a_o = a_q;
  assign b_o = b_q;
endmodule

// File: rtl/sm_pp_accum.sv
module sm_pp_accum #(
  parameter int unsigned LIMB_W = 16,
  parameter int unsigned N_LIMB = 28,
  parameter int unsigned ACC_W  = 40,
  localparam int unsigned CNT_W = $clog2(N_LIMB),
  localparam int unsigned OP_W  = N_LIMB * LIMB_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic                           en_i,
  input  logic [CNT_W-1:0]               j_i,
  input  logic [OP_W-1:0]                a_i,
  input  logic [LIMB_W-1:0]              b_limb_i,
  output logic [N_LIMB-1:0][ACC_W-1:0]   col_o
);
  localparam int FOLD = N_LIMB / 2;
  localparam int NL   = N_LIMB;

  logic [N_LIMB-1:0][2*LIMB_W-1:0] prod;
  logic [N_LIMB-1:0][ACC_W-1:0]    add_v, acc_q;

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      prod[i] = (2*LIMB_W)'(a_i[i*LIMB_W +: LIMB_W]) * (2*LIMB_W)'(b_limb_i);
    end
  end

  // column weight k = i+j; k>=N folds to k-N and k-N/2; k>=3N/2 folds twice
  always_comb begin
    add_v = '0;
    for (int i = 0; i < NL; i++) begin
      if (i + int'(j_i) < NL) begin
        add_v[i + int'(j_i)] += ACC_W'(prod[i]);
      end else if (i + int'(j_i) < NL + FOLD) begin
        add_v[i + int'(j_i) - NL]   += ACC_W'(prod[i]);
        add_v[i + int'(j_i) - FOLD] += ACC_W'(prod[i]);
      end else begin
        add_v[i + int'(j_i) - NL]        += ACC_W'(prod[i]) << 1;
        add_v[i + int'(j_i) - NL - FOLD] += ACC_W'(prod[i]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (en_i)   acc_q <= acc_q + add_v;
  end

  assign col_o = acc_q;

  for (genvar w = 0; w < NL; w++) begin : g_ovf
    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i && !clr_i |=> acc_q[w] >= $past(acc_q[w]));
  end
endmodule

// File: rtl/sm_fold_reduce.sv
module sm_fold_reduce #(
  parameter int unsigned LIMB_W = 16,
  parameter int unsigned N_LIMB = 28,
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned HALF_W = 224,
  localparam int unsigned FIELD_W = 2 * HALF_W,
  localparam int unsigned SUM_W   = FIELD_W + ACC_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         go_i,
  input  logic [N_LIMB-1:0][ACC_W-1:0] col_i,
  output logic                         done_o,
  output logic [FIELD_W-1:0]           res_o
);
  localparam logic [FIELD_W-1:0] PRIME = {FIELD_W{1'b1}} ^ (FIELD_W'(1) << HALF_W);
  localparam int NL = N_LIMB;

  logic [SUM_W-1:0]   s1_d, s1_q;
  logic [ACC_W-1:0]   hi1;
  logic [FIELD_W+1:0] s2_d, s2_q;
  logic [1:0]         hi2;
  logic [FIELD_W:0]   s3_d, s3_q;
  logic [FIELD_W-1:0] res_d, res_q;
  logic v1_q, v2_q, v3_q, res_v_q;

  always_comb begin
    s1_d = '0;
    for (int w = 0; w < NL; w++) begin
      s1_d = s1_d + (SUM_W'(col_i[w]) << (LIMB_W * w));
    end
  end

  assign hi1  = s1_q[SUM_W-1:FIELD_W];
  assign s2_d = (FIELD_W+2)'(s1_q[FIELD_W-1:0]) + (FIELD_W+2)'(hi1)
              + ((FIELD_W+2)'(hi1) << HALF_W);
  assign hi2  = s2_q[FIELD_W+1:FIELD_W];
  assign s3_d = (FIELD_W+1)'(s2_q[FIELD_W-1:0]) + (FIELD_W+1)'(hi2)
              + ((FIELD_W+1)'(hi2) << HALF_W);
  assign res_d = (s3_q >= (FIELD_W+1)'(PRIME)) ? FIELD_W'(s3_q - (FIELD_W+1)'(PRIME))
                                              : s3_q[FIELD_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0; v2_q <= 1'b0; v3_q <= 1'b0; res_v_q <= 1'b0;
      s1_q <= '0; s2_q <= '0; s3_q <= '0; res_q <= '0;
    end else begin
      v1_q    <= go_i;
      v2_q    <= v1_q;
      v3_q    <= v2_q;
      res_v_q <= v3_q;
      if (go_i) s1_q  <= s1_d;
      if (v1_q) s2_q  <= s2_d;
      if (v2_q) s3_q  <= s3_d;
      if (v3_q) res_q <= res_d;
    end
  end

  assign done_o = v3_q;
  assign res_o  = res_q;

  assert_fold_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v3_q |-> !s3_q[FIELD_W]);
  assert_reduced_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_v_q |-> res_q < PRIME);
  assert_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v3_q |-> $past(go_i, 3));
endmodule

// File: rtl/sm_word_stream.sv
module sm_word_stream #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned N_WORD = 14,
  localparam int unsigned FIELD_W = WORD_W * N_WORD,
  localparam int unsigned IDX_W   = $clog2(N_WORD)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [FIELD_W-1:0] res_i,
  output logic [WORD_W-1:0]  word_o,
  output logic               valid_o
);
  logic             act_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else if (go_i) begin
      act_q <= 1'b1;
      idx_q <= '0;
    end else if (act_q) begin
      if (idx_q == IDX_W'(N_WORD - 1)) act_q <= 1'b0;
      else                             idx_q <= idx_q + 1'b1;
    end
  end

  assign word_o  = res_i[idx_q*WORD_W +: WORD_W];
  assign valid_o = act_q;

  assert_word_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q) |-> $past(idx_q) == IDX_W'(N_WORD - 1));
endmodule

// File: rtl/solinas_mul448.sv
module solinas_mul448
  import solinas_mul_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LIMB_W = 16,
  parameter int unsigned HALF_W = 224
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fb_a_i,
  input  logic              fb_b_i,
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  output logic [WORD_W-1:0] res_o,
  output logic              res_valid_o
);
  localparam int unsigned FIELD_W = 2 * HALF_W;
  localparam int unsigned N_WORD  = FIELD_W / WORD_W;
  localparam int unsigned N_LIMB  = FIELD_W / LIMB_W;
  localparam int unsigned ACC_W   = 2 * LIMB_W + $clog2(4 * N_LIMB) + 1;
  localparam int unsigned CNT_W   = $clog2(N_LIMB);
  localparam int unsigned LD_W    = $clog2(N_WORD);

  mul_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic accept, ld_en, acc_clr, acc_en, go_q, red_done;
  logic [LD_W-1:0] ld_idx;
  logic [FIELD_W-1:0] op_a, op_b, res_full;
  logic [N_LIMB-1:0][ACC_W-1:0] cols;

  assign accept  = start_i && (state_q == ST_IDLE);
  assign ld_en   = accept || (state_q == ST_LOAD);
  assign ld_idx  = accept ? '0 : cnt_q[LD_W-1:0];
  assign acc_clr = (state_q == ST_LOAD) && (cnt_q == CNT_W'(N_WORD - 1));
  assign acc_en  = (state_q == ST_MUL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      go_q    <= 1'b0;
    end else begin
      go_q <= (state_q == ST_MUL) && (cnt_q == CNT_W'(N_LIMB - 1));
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_LOAD;
          cnt_q   <= CNT_W'(1);
        end
        ST_LOAD: if (cnt_q == CNT_W'(N_WORD - 1)) begin
          state_q <= ST_MUL;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        ST_MUL: if (cnt_q == CNT_W'(N_LIMB - 1)) begin
          state_q <= ST_RED;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        ST_RED: if (red_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sm_operand_load #(.WORD_W(WORD_W), .N_WORD(N_WORD)) i_load (
    .clk_i, .rst_ni,
    .en_i(ld_en), .start_i(accept), .fb_a_i, .fb_b_i, .idx_i(ld_idx),
    .ext_a_i(op_a_i), .ext_b_i(op_b_i), .fb_res_i(res_full),
    .a_o(op_a), .b_o(op_b)
  );

  sm_pp_accum #(.LIMB_W(LIMB_W), .N_LIMB(N_LIMB), .ACC_W(ACC_W)) i_accum (
    .clk_i, .rst_ni,
    .clr_i(acc_clr), .en_i(acc_en), .j_i(cnt_q),
    .a_i(op_a), .b_limb_i(op_b[cnt_q*LIMB_W +: LIMB_W]),
    .col_o(cols)
  );

  sm_fold_reduce #(.LIMB_W(LIMB_W), .N_LIMB(N_LIMB), .ACC_W(ACC_W), .HALF_W(HALF_W)) i_reduce (
    .clk_i, .rst_ni,
    .go_i(go_q), .col_i(cols), .done_o(red_done), .res_o(res_full)
  );

  sm_word_stream #(.WORD_W(WORD_W), .N_WORD(N_WORD)) i_stream (
    .clk_i, .rst_ni,
    .go_i(red_done), .res_i(res_full), .word_o(res_o), .valid_o(res_valid_o)
  );

  assert_start_idle_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD) && ($past(state_q) != ST_LOAD) |->
      ($past(state_q) == ST_IDLE) && $past(start_i));
  assert_operands_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MUL) && ($past(state_q) == ST_MUL) |-> $stable(op_a) && $stable(op_b));
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && $past(state_q) == ST_IDLE && $past(res_valid_o) == 1'b0
      |-> !res_valid_o);
endmodule

// File: tb/test_solinas_mul448.sv
`timescale 1ns/1ps
module test_solinas_mul448;
  localparam logic [447:0] P_REF = ~(448'd1 << 224);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, fb_a_i = 1'b0, fb_b_i = 1'b0;
  logic [31:0] op_a_i = '0, op_b_i = '0;
  logic [31:0] res_o;
  logic res_valid_o;

  int cyc = 0, n_chk = 0, n_err = 0, last_start = 0;
  bit chk_on = 1'b0;
  logic [447:0] last_res = '0;
  int due_q[$];
  logic [447:0] val_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  solinas_mul448 i_solinas_mul448 (
    .clk_i(clk), .rst_ni, .start_i, .fb_a_i, .fb_b_i,
    .op_a_i, .op_b_i, .res_o, .res_valid_o
  );

  function automatic logic [447:0] modmul(logic [447:0] x, logic [447:0] y);
    logic [895:0] t;
    t = {448'd0, x} * {448'd0, y};
    t = t % {448'd0, P_REF};
    return t[447:0];
  endfunction

  function automatic logic [447:0] rnd448();
    logic [447:0] v;
    for (int k = 0; k < 14; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  task automatic fail(string req, logic [447:0] got, logic [447:0] exp);
    n_err++;
    $display("FAIL %s cycle %0d got %h exp %h", req, cyc, got, exp);
  endtask

  // reference: per-cycle expected valid and word (R4, R3)
  always @(negedge clk) begin
    if (chk_on) begin
      logic exp_v;
      logic [447:0] tv;
      logic [31:0] w;
      while (due_q.size() > 0 && cyc >= due_q[0] + 14) begin
        void'(due_q.pop_front()); void'(val_q.pop_front()); void'(tag_q.pop_front());
      end
      exp_v = (due_q.size() > 0) && (cyc >= due_q[0]);
      n_chk++;
      if (res_valid_o !== exp_v)
        fail(due_q.size() > 0 ? {"R4 valid ", tag_q[0]} : "R4 valid idle",
             448'(res_valid_o), 448'(exp_v));
      else if (exp_v) begin
        tv = val_q[0] >> (32 * (cyc - due_q[0]));
        w  = tv[31:0];
        n_chk++;
        if (res_o !== w) fail({"R3 word ", tag_q[0]}, 448'(res_o), 448'(w));
      end
    end
  end

  // R2: word 0 with start, then 13 words, least significant first
  task automatic do_op(logic [447:0] a, logic [447:0] b, bit fa, bit fb, string tag);
    logic [447:0] ea, eb, r;
    int s;
    s  = cyc;
    ea = fa ? last_res : a;
    eb = fb ? last_res : b;
    r  = modmul(ea, eb);
    due_q.push_back(s + 46); val_q.push_back(r); tag_q.push_back(tag);
    last_res = r; last_start = s;
    for (int k = 0; k < 14; k++) begin
      start_i = (k == 0);
      fb_a_i  = (k == 0) ? fa : 1'b0;
      fb_b_i  = (k == 0) ? fb : 1'b0;
      op_a_i  = a[32*k +: 32];
      op_b_i  = b[32*k +: 32];
      @(negedge clk);
    end
    start_i = 1'b0; fb_a_i = 1'b0; fb_b_i = 1'b0;
  endtask

  task automatic wait_cyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // R7: spurious start with garbage while busy
  task automatic junk_start(int c);
    wait_cyc(c);
    start_i = 1'b1; fb_a_i = $urandom; fb_b_i = $urandom;
    op_a_i = $urandom; op_b_i = $urandom;
    @(negedge clk);
    start_i = 1'b0; fb_a_i = 1'b0; fb_b_i = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
    $finish;
  end

  initial begin
    logic [447:0] ones, c4[4];
    ones = '1;
    c4[0] = '0; c4[1] = 448'd1; c4[2] = P_REF - 448'd1; c4[3] = ones;
    // R1: outputs quiet in reset
    repeat (4) begin
      @(negedge clk);
      n_chk++;
      if (res_valid_o !== 1'b0) fail("R1 reset", 448'(res_valid_o), 448'd0);
    end
    rst_ni = 1'b1;
    @(negedge clk);
    chk_on = 1'b1;
    repeat (10) @(negedge clk);   // R1: still idle after reset

    // R3: corner operands, all pairs
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        do_op(c4[i], c4[j], 1'b0, 1'b0, "R3 corner");
        wait_cyc(last_start + 62);
      end
    do_op(P_REF, 448'd5, 1'b0, 1'b0, "R3 p");
    wait_cyc(last_start + 62);
    do_op(ones, P_REF + 448'd7, 1'b0, 1'b0, "R3 above p");
    wait_cyc(last_start + 62);

    // R2/R3: random operands and squares
    for (int n = 0; n < 16; n++) begin
      logic [447:0] x;
      x = rnd448();
      do_op(x, (n % 4 == 0) ? x : rnd448(), 1'b0, 1'b0, "R2/R3 random");
      wait_cyc(last_start + 62);
    end

    // R5: back-to-back starts in the first output cycle
    for (int n = 0; n < 6; n++) begin
      do_op(rnd448(), rnd448(), 1'b0, 1'b0, "R5 overlap");
      wait_cyc(last_start + 46);
    end
    wait_cyc(last_start + 62);

    // R6: feedback chains, external words are garbage
    do_op(rnd448(), rnd448(), 1'b0, 1'b0, "R6 seed");
    wait_cyc(last_start + 62);
    do_op(rnd448(), rnd448(), 1'b1, 1'b1, "R6 square");
    wait_cyc(last_start + 46);
    do_op(rnd448(), rnd448(), 1'b1, 1'b1, "R6 square b2b");
    wait_cyc(last_start + 46);
    do_op(rnd448(), ones, 1'b1, 1'b0, "R6 fb a");
    wait_cyc(last_start + 46);
    do_op(P_REF - 448'd1, rnd448(), 1'b0, 1'b1, "R6 fb b");
    wait_cyc(last_start + 62);

    // R7: starts during load-complete, multiply and final reduce are ignored
    for (int n = 0; n < 3; n++) begin
      int s;
      do_op(rnd448(), rnd448(), 1'b0, 1'b0, "R7 busy");
      s = last_start;
      junk_start(s + 14);
      junk_start(s + 30);
      junk_start(s + 44);
      junk_start(s + 45);
      wait_cyc(s + 62);
    end

    wait_cyc(last_start + 70);
    summary();
    $finish;
  end
endmodule